// File: doc/BRIEF.md
# UART Register Front End with Banked Access Modes

This block is the byte-wide register side of a 16550-class serial port with an enhanced register set. A host drives a simple select/write strobe bus with a 4-bit offset. The value last written to the line control register picks one of three access banks: operational, configuration A or configuration B. Several offsets decode to different registers depending on the bank. Two further gates apply: an enhanced-enable bit and a table-access bit. The bit serializer is not part of this block. Serial traffic appears as byte-wide strobes: the receive side pushes bytes in, and the transmit side pops bytes out.

The block holds a transmit queue and a receive queue of parameterised depth. It reports the receive fill level and a transmit-full flag. It raises an interrupt once the receive fill level reaches a programmable trigger. A mode register switches the port on and off. A soft-reset register returns every register and queue to its reset state, and a status register reports when that reset has completed.

Top module: `uart_regfront`

## Requirements
- R1: The line control register (offset 3) selects the bank. 0x80 or any other value with bit 7 set, except 0xBF, selects configuration A. 0xBF selects configuration B. A value with bit 7 clear selects operational. Offsets 0 and 1 reach the data holding / interrupt enable registers in operational, and divisor low / divisor high in both configuration banks.
- R2: Offset 2 reaches the enhanced register only in configuration B, where bit 4 is enhanced-enable. In the other banks it reaches the FIFO control register.
- R3: Offset 7 reaches the trigger-level register only while enhanced-enable and modem control (offset 4) bit 6 are both set. Otherwise it reaches a scratch byte. Offset 6 reaches the flow-threshold register under the same condition and reads 0 otherwise.
- R4: FIFO control bits 7:4 change on a write only while enhanced-enable is set. Bit 0 (queue enable) and bit 3 are always writable, and bits 2:1 read back as 0.
- R5: In operational, a write to offset 0 pushes into the transmit queue, which holds DEPTH (64) bytes. Offset 10 bit 0 reads 1 while the queue is full, and a write to a full queue is dropped. With the port on, tx_avail and tx_byte present the oldest byte, and tx_pop removes it.
- R6: Offset 13 returns the receive fill level. In operational, a read of offset 0 returns the oldest receive byte and removes it. A read from an empty receive queue returns the last byte removed and leaves the level at 0. A push to a full receive queue is dropped.
- R7: irq is high when interrupt enable bit 0 is set, the port is on, and the receive level is at or above the trigger. With supplementary control (offset 9) bit 7 clear, the trigger is 8, 16, 56 or 60, selected by FIFO control bits 7:6. With it set, the trigger is trigger-level bits 7:4, where 0 counts as 1.
- R8: With FIFO control bit 0 clear, each queue holds a single byte.
- R9: The mode register (offset 8, bits 2:0) resets to 7. Value 0 turns the port on and any other value turns it off. While off, tx_avail and irq are 0 and rx_push is ignored.
- R10: Writing 1 to bit 1 of offset 11 causes a soft reset. In the cycle after the write, offset 12 bit 0 reads 0. From the following cycle it reads 1, and every register and queue holds its reset value.
- R11: After reset, line control reads 0, the mode register reads 7, offset 12 reads 1, the receive level reads 0, and irq and tx_avail are 0.
- R12: A FIFO control write clears the receive queue when bit 1 is set, and clears the transmit queue when bit 2 is set. A write that changes bit 0 clears both queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from offset and bank |
| rx_push | input | 1 | Receive byte strobe from the serial side |
| rx_byte | input | 8 | Received byte |
| tx_pop | input | 1 | Transmit byte taken by the serial side |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_avail | output | 1 | Transmit byte available and port on |
| irq | output | 1 | Receive-level interrupt |

## Verification
A wrong bank or gate decode shows at once: the next read of the shared offset returns a neighbour register's byte. A queue pointer or count error first appears on the fill-level read. It then shows as a wrong byte order on tx_byte or on the holding read, within the same burst of pushes and pops. A wrong trigger shows as irq rising one entry early or late at the exact boundary push. A faulty soft-reset sequence shows on the status read in the single cycle after the request, and on register reads one cycle later.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    localparam int BYTE_W = 8;

    // line control codes that pick a bank
    localparam logic [7:0] LCR_CFG_A = 8'h80;
    localparam logic [7:0] LCR_CFG_B = 8'hBF;

    // bit positions decoded by neighbours
    localparam int EFR_ENH_BIT    = 4;
    localparam int MCR_TABLE_BIT  = 6;
    localparam int SCR_GRAN_BIT   = 7;
    localparam int SYSC_SRST_BIT  = 1;
    localparam int FCR_EN_BIT     = 0;
    localparam int FCR_RXCLR_BIT  = 1;
    localparam int FCR_TXCLR_BIT  = 2;

    typedef enum logic [1:0] {
        BANK_OP,
        BANK_CFG_A,
        BANK_CFG_B
    } bank_e;

    typedef enum logic [4:0] {
        SEL_NONE,
        SEL_HOLD,
        SEL_DLL,
        SEL_DLH,
        SEL_IER,
        SEL_FCR,
        SEL_EFR,
        SEL_LCR,
        SEL_MCR,
        SEL_TCR,
        SEL_TLR,
        SEL_SPR,
        SEL_MDR,
        SEL_SCR,
        SEL_SSR,
        SEL_SYSC,
        SEL_SYSS,
        SEL_RXLVL
    } reg_sel_e;

    typedef struct packed {
        logic [7:0] dll;
        logic [7:0] dlh;
        logic [7:0] ier;
        logic [7:0] fcr;
        logic [7:0] efr;
        logic [7:0] lcr;
        logic [7:0] mcr;
        logic [7:0] tcr;
        logic [7:0] tlr;
        logic [7:0] spr;
        logic [7:0] scr;
        logic [2:0] mdr;
    } cfg_regs_t;

    localparam logic [2:0] MDR_OFF  = 3'd7;
    localparam logic [2:0] MDR_UART = 3'd0;

    function automatic bank_e bank_of(input logic [7:0] lcr);
        if (lcr == LCR_CFG_B)
            return BANK_CFG_B;
        else if (lcr[7])
            return BANK_CFG_A;
        else
            return BANK_OP;
    endfunction

    function automatic int unsigned coarse_trig(input logic [1:0] code);
        case (code)
            2'd0:    return 8;
            2'd1:    return 16;
            2'd2:    return 56;
            default: return 60;
        endcase
    endfunction

    function automatic cfg_regs_t regs_reset();
        cfg_regs_t r;
        r     = '0;
        r.mdr = MDR_OFF;
        return r;
    endfunction

endpackage

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [CW-1:0]    limit,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             full, do_push, do_pop;

    assign full    = (count >= limit);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= bump(wr_ptr);
            if (do_pop)
                rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R5
    drop_full_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !clr && count >= limit) |=> (count == $past(count)));

    // R6
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !clr && count == '0) |=> (count == '0));

    // R8
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= limit);

endmodule

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
    import uart_rf_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        lcr,
    input  logic              enh,
    input  logic              table_bit,
    output reg_sel_e          sel
);

    bank_e bank;
    logic  table_ok;

    always_comb begin
        bank     = bank_of(lcr);
        table_ok = enh && table_bit;
        case (addr)
            ADDR_W'(0):  sel = (bank == BANK_OP) ? SEL_HOLD : SEL_DLL;
            ADDR_W'(1):  sel = (bank == BANK_OP) ? SEL_IER : SEL_DLH;
            ADDR_W'(2):  sel = (bank == BANK_CFG_B) ? SEL_EFR : SEL_FCR;
            ADDR_W'(3):  sel = SEL_LCR;
            ADDR_W'(4):  sel = SEL_MCR;
            ADDR_W'(6):  sel = table_ok ? SEL_TCR : SEL_NONE;
            ADDR_W'(7):  sel = table_ok ? SEL_TLR : SEL_SPR;
            ADDR_W'(8):  sel = SEL_MDR;
            ADDR_W'(9):  sel = SEL_SCR;
            ADDR_W'(10): sel = SEL_SSR;
            ADDR_W'(11): sel = SEL_SYSC;
            ADDR_W'(12): sel = SEL_SYSS;
            ADDR_W'(13): sel = SEL_RXLVL;
            default:     sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
    import uart_rf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] rx_count,
    input  logic          gran,
    input  logic [3:0]    tlr_rx,
    input  logic [1:0]    fcr_code,
    input  logic          rx_ie,
    input  logic          port_on,
    output logic          irq
);

    logic [CW-1:0] trig;

    always_comb begin
        if (gran)
            trig = (tlr_rx == 4'd0) ? CW'(1) : CW'(tlr_rx);
        else
            trig = CW'(coarse_trig(fcr_code));
        if (trig > CW'(DEPTH))
            trig = CW'(DEPTH);
        irq = port_on && rx_ie && (rx_count >= trig);
    end

    // R7
    irq_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (rx_count != '0));

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import uart_rf_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              rx_push,
    input  logic [7:0]        rx_byte,
    input  logic              tx_pop,
    output logic [7:0]        tx_byte,
    output logic              tx_avail,
    output logic              irq
);

    cfg_regs_t     regs_q;
    reg_sel_e      sel;
    logic          soft_q, irst;
    logic          wr_stb, rd_stb, port_on;
    logic          fcr_wr, fen_change, rx_clr, tx_clr;
    logic [CW-1:0] limit, rx_count, tx_count;
    logic          rx_empty, tx_empty, tx_full;
    logic [7:0]    rx_head, last_rx;
    logic          rx_pop_req, tx_push_req;

    assign irst    = rst || soft_q;
    assign wr_stb  = bus_sel && bus_wr;
    assign rd_stb  = bus_sel && !bus_wr;
    assign port_on = (regs_q.mdr == MDR_UART);
    assign limit   = regs_q.fcr[FCR_EN_BIT] ? CW'(DEPTH) : CW'(1);
    assign tx_full = (tx_count >= limit);

    uart_rf_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr      (bus_addr),
        .lcr       (regs_q.lcr),
        .enh       (regs_q.efr[EFR_ENH_BIT]),
        .table_bit (regs_q.mcr[MCR_TABLE_BIT]),
        .sel       (sel)
    );

    assign fcr_wr      = wr_stb && (sel == SEL_FCR);
    assign fen_change  = fcr_wr && (bus_wdata[FCR_EN_BIT] != regs_q.fcr[FCR_EN_BIT]);
    assign rx_clr      = fcr_wr && (bus_wdata[FCR_RXCLR_BIT] || fen_change);
    assign tx_clr      = fcr_wr && (bus_wdata[FCR_TXCLR_BIT] || fen_change);
    assign rx_pop_req  = rd_stb && (sel == SEL_HOLD);
    assign tx_push_req = wr_stb && (sel == SEL_HOLD);

    uart_rf_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_rx_fifo (
        .clk   (clk),
        .rst   (irst),
        .clr   (rx_clr),
        .limit (limit),
        .push  (rx_push && port_on),
        .din   (rx_byte),
        .pop   (rx_pop_req),
        .dout  (rx_head),
        .count (rx_count),
        .empty (rx_empty)
    );

    uart_rf_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_tx_fifo (
        .clk   (clk),
        .rst   (irst),
        .clr   (tx_clr),
        .limit (limit),
        .push  (tx_push_req),
        .din   (bus_wdata),
        .pop   (tx_pop && port_on),
        .dout  (tx_byte),
        .count (tx_count),
        .empty (tx_empty)
    );

    assign tx_avail = port_on && !tx_empty;

    uart_rf_irq #(.DEPTH(DEPTH)) u_irq (
        .clk      (clk),
        .rst      (irst),
        .rx_count (rx_count),
        .gran     (regs_q.scr[SCR_GRAN_BIT]),
        .tlr_rx   (regs_q.tlr[7:4]),
        .fcr_code (regs_q.fcr[7:6]),
        .rx_ie    (regs_q.ier[0]),
        .port_on  (port_on),
        .irq      (irq)
    );

    // soft reset request lives outside the block reset it triggers
    always_ff @(posedge clk) begin
        if (rst)
            soft_q <= 1'b0;
        else
            soft_q <= wr_stb && (sel == SEL_SYSC) && bus_wdata[SYSC_SRST_BIT] && !soft_q;
    end

    always_ff @(posedge clk) begin
        if (irst) begin
            regs_q  <= regs_reset();
            last_rx <= '0;
        end else begin
            if (rx_pop_req && !rx_empty)
                last_rx <= rx_head;
            if (wr_stb) begin
                case (sel)
                    SEL_DLL: regs_q.dll <= bus_wdata;
                    SEL_DLH: regs_q.dlh <= bus_wdata;
                    SEL_IER: regs_q.ier <= bus_wdata;
                    SEL_FCR: begin
                        regs_q.fcr[FCR_EN_BIT] <= bus_wdata[FCR_EN_BIT];
                        regs_q.fcr[3]          <= bus_wdata[3];
                        if (regs_q.efr[EFR_ENH_BIT])
                            regs_q.fcr[7:4] <= bus_wdata[7:4];
                    end
                    SEL_EFR: regs_q.efr <= bus_wdata;
                    SEL_LCR: regs_q.lcr <= bus_wdata;
                    SEL_MCR: regs_q.mcr <= bus_wdata;
                    SEL_TCR: regs_q.tcr <= bus_wdata;
                    SEL_TLR: regs_q.tlr <= bus_wdata;
                    SEL_SPR: regs_q.spr <= bus_wdata;
                    SEL_MDR: regs_q.mdr <= bus_wdata[2:0];
                    SEL_SCR: regs_q.scr <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (sel)
            SEL_HOLD:  bus_rdata = rx_empty ? last_rx : rx_head;
            SEL_DLL:   bus_rdata = regs_q.dll;
            SEL_DLH:   bus_rdata = regs_q.dlh;
            SEL_IER:   bus_rdata = regs_q.ier;
            SEL_FCR:   bus_rdata = regs_q.fcr;
            SEL_EFR:   bus_rdata = regs_q.efr;
            SEL_LCR:   bus_rdata = regs_q.lcr;
            SEL_MCR:   bus_rdata = regs_q.mcr;
            SEL_TCR:   bus_rdata = regs_q.tcr;
            SEL_TLR:   bus_rdata = regs_q.tlr;
            SEL_SPR:   bus_rdata = regs_q.spr;
            SEL_MDR:   bus_rdata = {5'd0, regs_q.mdr};
            SEL_SCR:   bus_rdata = regs_q.scr;
            SEL_SSR:   bus_rdata = {7'd0, tx_full};
            SEL_SYSS:  bus_rdata = {7'd0, !soft_q};
            SEL_RXLVL: bus_rdata = 8'(rx_count);
            default:   bus_rdata = 8'd0;
        endcase
    end

    // R2
    efr_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_EFR) |-> (regs_q.lcr == LCR_CFG_B));

    // R10
    soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
        soft_q |=> (regs_q.mdr == MDR_OFF && regs_q.lcr == 8'h00 && rx_count == '0));

    // R9
    rx_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!port_on && !soft_q && !rx_clr && !rx_pop_req) |=> (rx_count == $past(rx_count)));

endmodule

// File: tb/uart_regfront_bench.sv
module uart_regfront_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       rx_push = 1'b0, tx_pop = 1'b0;
    logic [7:0] rx_byte = '0, tx_byte;
    logic       tx_avail, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    uart_regfront u_uart_regfront (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_push(rx_push), .rx_byte(rx_byte), .tx_pop(tx_pop),
        .tx_byte(tx_byte), .tx_avail(tx_avail), .irq(irq)
    );

    task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string rq, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(rq, d, exp);
    endtask

    task automatic push_rx(input logic [7:0] d);
        @(negedge clk);
        rx_push = 1'b1; rx_byte = d;
        @(posedge clk); #1;
        rx_push = 1'b0;
    endtask

    task automatic pop_tx();
        @(negedge clk);
        tx_pop = 1'b1;
        @(posedge clk); #1;
        tx_pop = 1'b0;
    endtask

    task automatic pins_chk(input string rq, input logic exp_avail, input logic exp_irq);
        @(negedge clk); #1;
        chk({rq, " tx_avail"}, {7'd0, tx_avail}, {7'd0, exp_avail});
        chk({rq, " irq"}, {7'd0, irq}, {7'd0, exp_irq});
    endtask

    task automatic t_reset_state();
        rd_chk("R11 lcr", 4'd3, 8'h00);
        rd_chk("R11 mdr", 4'd8, 8'h07);
        rd_chk("R11 syss", 4'd12, 8'h01);
        rd_chk("R11 rxlvl", 4'd13, 8'h00);
        pins_chk("R11", 1'b0, 1'b0);
    endtask

    task automatic t_banks();
        wr(4'd1, 8'h01);
        wr(4'd3, 8'h80);
        wr(4'd1, 8'h5A);
        rd_chk("R1 cfgA dlh", 4'd1, 8'h5A);
        wr(4'd3, 8'h03);
        rd_chk("R1 op ier", 4'd1, 8'h01);
        wr(4'd3, 8'hBF);
        rd_chk("R1 cfgB dlh", 4'd1, 8'h5A);
        rd_chk("R1 cfgB dll", 4'd0, 8'h00);
    endtask

    task automatic t_efr();
        rd_chk("R2 efr reset", 4'd2, 8'h00);
        wr(4'd2, 8'h10);
        rd_chk("R2 efr write", 4'd2, 8'h10);
        wr(4'd3, 8'h80);
        rd_chk("R2 cfgA off2 is fcr", 4'd2, 8'h00);
    endtask

    task automatic t_table_gate();
        wr(4'd7, 8'h33);
        rd_chk("R3 scratch", 4'd7, 8'h33);
        rd_chk("R3 off6 closed", 4'd6, 8'h00);
        wr(4'd4, 8'h40);
        rd_chk("R3 tlr open", 4'd7, 8'h00);
        wr(4'd7, 8'h20);
        wr(4'd6, 8'h9C);
        rd_chk("R3 tlr write", 4'd7, 8'h20);
        rd_chk("R3 tcr write", 4'd6, 8'h9C);
        wr(4'd4, 8'h00);
        rd_chk("R3 scratch kept", 4'd7, 8'h33);
    endtask

    task automatic t_fcr_gate();
        wr(4'd3, 8'hBF); wr(4'd2, 8'h00); wr(4'd3, 8'h03);
        wr(4'd2, 8'hC1);
        rd_chk("R4 upper locked", 4'd2, 8'h01);
        wr(4'd3, 8'hBF); wr(4'd2, 8'h10); wr(4'd3, 8'h03);
        wr(4'd2, 8'hC1);
        rd_chk("R4 upper open", 4'd2, 8'hC1);
        wr(4'd2, 8'h0F);
        rd_chk("R4 clear bits not stored", 4'd2, 8'h09);
        wr(4'd2, 8'h01);
    endtask

    task automatic t_tx_path();
        wr(4'd0, 8'hB1); wr(4'd0, 8'hB2); wr(4'd0, 8'hB3);
        pins_chk("R9 off", 1'b0, 1'b0);
        push_rx(8'h77);
        rd_chk("R9 rx ignored off", 4'd13, 8'h00);
        wr(4'd8, 8'h00);
        pins_chk("R5 on", 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk("R5 tx order", tx_byte, 8'hB1 + 8'(i));
            pop_tx();
        end
        for (int i = 0; i < 63; i++) wr(4'd0, 8'(i));
        rd_chk("R5 not full at 63", 4'd10, 8'h00);
        wr(4'd0, 8'd63);
        rd_chk("R5 full at 64", 4'd10, 8'h01);
        wr(4'd0, 8'hEE);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk); #1;
            chk("R5 drain", tx_byte, 8'(i));
            pop_tx();
        end
        pins_chk("R5 drained", 1'b0, 1'b0);
    endtask

    task automatic t_rx_path();
        push_rx(8'hA1); push_rx(8'hA2); push_rx(8'hA3);
        rd_chk("R6 level 3", 4'd13, 8'h03);
        rd_chk("R6 pop 1", 4'd0, 8'hA1);
        rd_chk("R6 pop 2", 4'd0, 8'hA2);
        rd_chk("R6 level 1", 4'd13, 8'h01);
        rd_chk("R6 pop 3", 4'd0, 8'hA3);
        rd_chk("R6 empty pop", 4'd0, 8'hA3);
        rd_chk("R6 level 0", 4'd13, 8'h00);
        for (int i = 0; i < 65; i++) push_rx(8'(i));
        rd_chk("R6 level cap", 4'd13, 8'd64);
        rd_chk("R6 oldest kept", 4'd0, 8'h00);
        wr(4'd2, 8'h03);
        rd_chk("R12 rx flush", 4'd13, 8'h00);
    endtask

    task automatic t_irq();
        for (int i = 0; i < 7; i++) push_rx(8'(i));
        pins_chk("R7 below 8", 1'b0, 1'b0);
        push_rx(8'h07);
        pins_chk("R7 at 8", 1'b0, 1'b1);
        rd_chk("R7 pop", 4'd0, 8'h00);
        pins_chk("R7 at 7", 1'b0, 1'b0);
        wr(4'd2, 8'h41);
        for (int i = 0; i < 8; i++) push_rx(8'(i));
        pins_chk("R7 at 15 of 16", 1'b0, 1'b0);
        push_rx(8'h08);
        pins_chk("R7 at 16", 1'b0, 1'b1);
        wr(4'd2, 8'h03);
        wr(4'd9, 8'h80);
        push_rx(8'h01);
        pins_chk("R7 fine 1 of 2", 1'b0, 1'b0);
        push_rx(8'h02);
        pins_chk("R7 fine 2", 1'b0, 1'b1);
        wr(4'd4, 8'h40); wr(4'd7, 8'h00); wr(4'd4, 8'h00);
        wr(4'd2, 8'h03);
        pins_chk("R7 empty", 1'b0, 1'b0);
        push_rx(8'h05);
        pins_chk("R7 zero as one", 1'b0, 1'b1);
        wr(4'd1, 8'h00);
        pins_chk("R7 ie off", 1'b0, 1'b0);
        wr(4'd1, 8'h01);
    endtask

    task automatic t_no_fifo();
        wr(4'd2, 8'h00);
        rd_chk("R12 enable change flush", 4'd13, 8'h00);
        push_rx(8'h11); push_rx(8'h22);
        rd_chk("R8 rx one deep", 4'd13, 8'h01);
        rd_chk("R8 rx byte", 4'd0, 8'h11);
        wr(4'd0, 8'h55);
        rd_chk("R8 tx full at 1", 4'd10, 8'h01);
        wr(4'd0, 8'h66);
        @(negedge clk); #1;
        chk("R8 tx byte", tx_byte, 8'h55);
        pop_tx();
        pins_chk("R8 tx empty", 1'b0, 1'b0);
    endtask

    task automatic t_port_off();
        wr(4'd2, 8'h01);
        push_rx(8'h42);
        pins_chk("R9 on irq", 1'b0, 1'b1);
        wr(4'd0, 8'h43);
        wr(4'd8, 8'h07);
        pins_chk("R9 off again", 1'b0, 1'b0);
    endtask

    task automatic t_soft_reset();
        wr(4'd3, 8'h80);
        wr(4'd11, 8'h02);
        rd_chk("R10 in reset", 4'd12, 8'h00);
        rd_chk("R10 done", 4'd12, 8'h01);
        rd_chk("R10 lcr", 4'd3, 8'h00);
        rd_chk("R10 mdr", 4'd8, 8'h07);
        rd_chk("R10 rxlvl", 4'd13, 8'h00);
        rd_chk("R10 ier", 4'd1, 8'h00);
        wr(4'd8, 8'h00);
        pins_chk("R10 tx flushed", 1'b0, 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_banks();
        t_efr();
        t_table_gate();
        t_fcr_gate();
        t_tx_path();
        t_rx_path();
        t_irq();
        t_no_fifo();
        t_port_off();
        t_soft_reset();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule